// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the decoder of a RISC-V style pipeline and decides whether the instruction word now in decode has to be turned into an illegal-instruction exception. Its inputs are the 32-bit instruction word, the hart's current privilege level, the three trap-control bits from the machine status register (timeout-wait, trap-virtual-memory, trap-supervisor-return) and a strap that tells whether supervisor mode exists at all. Its outputs are a trap flag, the exception cause code and the trap value to be written into the trap-value register.

Only a small set of words is judged: the all-zero word, WFI, SFENCE.VMA, SRET and any CSR instruction that addresses the supervisor address-translation register (CSR 0x180). Every other word passes unflagged, so that full decoding stays with the decoder. With the parameter `REG_OUT` at 1 (the default) the results leave a register one clock after the inputs. With `REG_OUT` at 0 they follow the inputs combinationally.

The word is first sorted into one class: OTHER, ZERO, WFI, SFENCE, SRET or SATP. A policy stage then weighs that class against the privilege and control bits. An output stage forms the cause code and trap value and registers them when asked to.

Top module: `priv_trap_checker`

## Requirements
- R1: The all-zero word is flagged illegal at every privilege level, whatever the control bits are.
- R2: WFI (word 0x10500073) at supervisor privilege (priv = 1) traps when the timeout-wait bit is 1 and passes when it is 0. Supervisor-mode presence has no effect on it.
- R3: SFENCE.VMA (bits 31:25 = 0001001, bits 14:7 = 0, opcode 1110011, any rs1/rs2) at supervisor privilege, with supervisor mode present, traps exactly when the trap-virtual-memory bit is 1.
- R4: A CSR instruction (opcode 1110011, bits 14:12 one of 1, 2, 3, 5, 6, 7) with CSR number 0x180 in bits 31:20, at supervisor privilege with supervisor mode present, traps exactly when the trap-virtual-memory bit is 1. A word with the same CSR field but bits 14:12 = 4 is not such an access.
- R5: SRET (word 0x10200073) at supervisor privilege, with supervisor mode present, traps exactly when the trap-supervisor-return bit is 1.
- R6: At machine privilege (priv = 3) no nonzero word is flagged, whatever the three control bits are.
- R7: At user privilege (priv = 0), and at the reserved level priv = 2, WFI, SFENCE.VMA, SRET and satp access always trap.
- R8: When supervisor mode is absent, SRET, SFENCE.VMA and satp access trap at every privilege below machine, whatever the control bits are.
- R9: The cause output is 2 (illegal instruction) when the trap flag is set and 0 otherwise.
- R10: The trap-value output carries the complete 32-bit word when the trap flag is set and is 0 otherwise.
- R11: Words outside the judged set are never flagged. This includes an arithmetic instruction, MRET, ECALL and CSR access to numbers other than 0x180.
- R12: With `REG_OUT` = 1, the results appear one clock after the inputs are presented, and an active-low reset holds every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, clears the registered outputs |
| insn_i | input | 32 | Instruction word in decode |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| tw_i | input | 1 | Timeout-wait control bit |
| tvm_i | input | 1 | Trap-virtual-memory control bit |
| tsr_i | input | 1 | Trap-supervisor-return control bit |
| s_mode_en_i | input | 1 | 1 when supervisor mode is implemented |
| illegal_o | output | 1 | Illegal-instruction trap required |
| cause_o | output | 4 | Exception cause code |
| tval_o | output | 32 | Trap value (faulting word or zero) |

## Verification
All three results come from the same input set and land together, exactly one rising edge after that set is applied, because only the output register lies between them. The driver applies one input set on each falling edge and queues its expected flag. The monitor looks a short time after the following rising edge and pops one item each time, so every comparison falls on the cycle that carries that stimulus and never on its neighbour. The reset state is sampled directly while reset is held, before the queue starts.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    localparam int unsigned ILL_CAUSE_CODE = 2;

    localparam logic [6:0]  OPC_SYSTEM  = 7'b1110011;
    localparam logic [31:0] WORD_WFI    = 32'h1050_0073;
    localparam logic [31:0] WORD_SRET   = 32'h1020_0073;
    localparam logic [6:0]  F7_SFENCE   = 7'b0001001;
    localparam logic [11:0] CSR_ATP     = 12'h180;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_t;

    typedef enum logic [2:0] {
        CLS_OTHER  = 3'd0,
        CLS_ZERO   = 3'd1,
        CLS_WFI    = 3'd2,
        CLS_SFENCE = 3'd3,
        CLS_SRET   = 3'd4,
        CLS_SATP   = 3'd5
    } insn_cls_t;

endpackage

// File: rtl/insn_classifier.sv
module insn_classifier
    import priv_trap_pkg::*;
#(
    parameter int unsigned ILEN = 32
) (
    input  logic [ILEN-1:0] insn_i,
    output insn_cls_t       cls_o
);

    logic is_system;
    logic is_csr_op;

    always_comb begin
        is_system = (insn_i[6:0] == OPC_SYSTEM);
        // CSR forms use funct3 1,2,3,5,6,7; 0 is the privileged group, 4 is reserved
        is_csr_op = is_system && (insn_i[13:12] != 2'b00);
    end

    always_comb begin
        if (insn_i == '0) begin
            cls_o = CLS_ZERO;
        end else if (insn_i == WORD_WFI) begin
            cls_o = CLS_WFI;
        end else if (insn_i == WORD_SRET) begin
            cls_o = CLS_SRET;
        end else if (is_system && insn_i[31:25] == F7_SFENCE && insn_i[14:7] == '0) begin
            cls_o = CLS_SFENCE;
        end else if (is_csr_op && insn_i[31:20] == CSR_ATP) begin
            cls_o = CLS_SATP;
        end else begin
            cls_o = CLS_OTHER;
        end
    end

endmodule

// File: rtl/trap_policy.sv
module trap_policy
    import priv_trap_pkg::*;
(
    input  insn_cls_t  cls_i,
    input  logic [1:0] priv_i,
    input  logic       tw_i,
    input  logic       tvm_i,
    input  logic       tsr_i,
    input  logic       s_mode_en_i,
    output logic       illegal_o
);

    logic in_mach;
    logic in_sup;

    always_comb begin
        in_mach = (priv_t'(priv_i) == PRIV_M);
        in_sup  = (priv_t'(priv_i) == PRIV_S);
    end

    always_comb begin
        unique case (cls_i)
            CLS_ZERO:   illegal_o = 1'b1;
            CLS_WFI:    illegal_o = !in_mach && (!in_sup || tw_i);
            CLS_SFENCE,
            CLS_SATP:   illegal_o = !in_mach && (!in_sup || tvm_i || !s_mode_en_i);
            CLS_SRET:   illegal_o = !in_mach && (!in_sup || tsr_i || !s_mode_en_i);
            default:    illegal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage
    import priv_trap_pkg::*;
#(
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned ILEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               illegal_d,
    input  logic [ILEN-1:0]    insn_d,
    output logic               illegal_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [ILEN-1:0]    tval_o
);

    localparam logic [CAUSE_W-1:0] CAUSE_ILL = CAUSE_W'(ILL_CAUSE_CODE);

    logic [CAUSE_W-1:0] cause_d;
    logic [ILEN-1:0]    tval_d;

    always_comb begin
        cause_d = illegal_d ? CAUSE_ILL : '0;
        tval_d  = illegal_d ? insn_d : '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    illegal_o <= 1'b0;
                    cause_o   <= '0;
                    tval_o    <= '0;
                end else begin
                    illegal_o <= illegal_d;
                    cause_o   <= cause_d;
                    tval_o    <= tval_d;
                end
            end
        end else begin : g_comb
            always_comb begin
                illegal_o = illegal_d;
                cause_o   = cause_d;
                tval_o    = tval_d;
            end
        end
    endgenerate

endmodule

// File: rtl/priv_trap_checker.sv
module priv_trap_checker
    import priv_trap_pkg::*;
#(
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned ILEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ILEN-1:0]    insn_i,
    input  logic [1:0]         priv_i,
    input  logic               tw_i,
    input  logic               tvm_i,
    input  logic               tsr_i,
    input  logic               s_mode_en_i,
    output logic               illegal_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [ILEN-1:0]    tval_o
);

    insn_cls_t cls;
    logic      illegal_d;

    insn_classifier #(
        .ILEN (ILEN)
    ) u_classify (
        .insn_i (insn_i),
        .cls_o  (cls)
    );

    trap_policy u_policy (
        .cls_i       (cls),
        .priv_i      (priv_i),
        .tw_i        (tw_i),
        .tvm_i       (tvm_i),
        .tsr_i       (tsr_i),
        .s_mode_en_i (s_mode_en_i),
        .illegal_o   (illegal_d)
    );

    trap_out_stage #(
        .REG_OUT (REG_OUT),
        .ILEN    (ILEN),
        .CAUSE_W (CAUSE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .illegal_d (illegal_d),
        .insn_d    (insn_i),
        .illegal_o (illegal_o),
        .cause_o   (cause_o),
        .tval_o    (tval_o)
    );

endmodule

// File: rtl/priv_trap_checker_sva.sv
module priv_trap_checker_sva
    import priv_trap_pkg::*;
#(
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned ILEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ILEN-1:0]    insn_i,
    input logic [1:0]         priv_i,
    input logic               tw_i,
    input logic               tsr_i,
    input logic               s_mode_en_i,
    input logic               illegal_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [ILEN-1:0]    tval_o
);

    generate
        if (REG_OUT) begin : g_seq
            logic past_ok;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) past_ok <= 1'b0;
                else        past_ok <= 1'b1;
            end

            AST_ZERO_WORD_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(insn_i) == '0) |-> illegal_o); // R1
            AST_WFI_FOLLOWS_TW: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(insn_i) == WORD_WFI && $past(priv_i) == 2'd1)
                |-> (illegal_o == $past(tw_i))); // R2
            AST_SRET_FOLLOWS_TSR: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(insn_i) == WORD_SRET && $past(priv_i) == 2'd1 && $past(s_mode_en_i))
                |-> (illegal_o == $past(tsr_i))); // R5
            AST_MACHINE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(priv_i) == 2'd3 && $past(insn_i) != '0) |-> !illegal_o); // R6
            AST_TVAL_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && illegal_o) |-> (tval_o == $past(insn_i))); // R10
            AST_CAUSE_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                cause_o == (illegal_o ? CAUSE_W'(ILL_CAUSE_CODE) : '0)); // R9
            AST_RESET_CLEARS: assert property (@(posedge clk)
                !rst_n |-> (!illegal_o && cause_o == '0 && tval_o == '0)); // R12
        end else begin : g_comb
            always_comb begin
                if (rst_n) begin
                    AST_ZERO_WORD_TRAPS_C: assert (insn_i != '0 || illegal_o); // R1
                    AST_MACHINE_NO_TRAP_C: assert (priv_i != 2'd3 || insn_i == '0 || !illegal_o); // R6
                    AST_TVAL_IS_WORD_C: assert (!illegal_o || tval_o == insn_i); // R10
                    AST_CAUSE_MATCHES_FLAG_C: assert (cause_o == (illegal_o ? CAUSE_W'(ILL_CAUSE_CODE) : '0)); // R9
                end
            end
        end
    endgenerate

endmodule

bind priv_trap_checker priv_trap_checker_sva #(
    .REG_OUT (REG_OUT),
    .ILEN    (ILEN),
    .CAUSE_W (CAUSE_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_i      (insn_i),
    .priv_i      (priv_i),
    .tw_i        (tw_i),
    .tsr_i       (tsr_i),
    .s_mode_en_i (s_mode_en_i),
    .illegal_o   (illegal_o),
    .cause_o     (cause_o),
    .tval_o      (tval_o)
);

// File: tb/priv_trap_checker_tb_top.sv
`timescale 1ns/1ps
module priv_trap_checker_tb_top;

    localparam logic [31:0] W_NOP    = 32'h0000_0013;
    localparam logic [31:0] W_WFI    = 32'h1050_0073;
    localparam logic [31:0] W_SRET   = 32'h1020_0073;
    localparam logic [31:0] W_MRET   = 32'h3020_0073;
    localparam logic [31:0] W_ECALL  = 32'h0000_0073;
    localparam logic [31:0] W_SFENCE = 32'h12A5_8073;
    localparam logic [31:0] W_ATP_RD = 32'h1800_22F3;
    localparam logic [31:0] W_ATP_WR = 32'h1802_9073;
    localparam logic [31:0] W_ATP_F4 = 32'h1800_4073;
    localparam logic [31:0] W_SST_RD = 32'h1000_22F3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = W_NOP;
    logic [1:0]  priv = 2'd3;
    logic        tw = 1'b0, tvm = 1'b0, tsr = 1'b0, sen = 1'b1;
    logic        illegal;
    logic [3:0]  cause;
    logic [31:0] tval;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    priv_trap_checker dut_i (
        .clk (clk), .rst_n (rst_n), .insn_i (insn), .priv_i (priv),
        .tw_i (tw), .tvm_i (tvm), .tsr_i (tsr), .s_mode_en_i (sen),
        .illegal_o (illegal), .cause_o (cause), .tval_o (tval)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [31:0] w, input logic [1:0] p,
                         input logic t_w, input logic t_vm, input logic t_sr,
                         input logic s_en, input logic exp);
        item_t it;
        @(negedge clk);
        insn = w; priv = p; tw = t_w; tvm = t_vm; tsr = t_sr; sen = s_en;
        it.word = w; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: the result of a set driven on a falling edge is due at the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, "illegal", {31'd0, illegal}, {31'd0, it.exp});
                check("R9", "cause", {28'd0, cause}, it.exp ? 32'd2 : 32'd0);
                check("R10", "tval", tval, it.exp ? it.word : 32'd0);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        insn = 32'h0;
        repeat (3) @(posedge clk);
        #2;
        // R12: reset holds outputs low even with a trapping word applied
        check("R12", "reset illegal", {31'd0, illegal}, 32'd0);
        check("R12", "reset cause", {28'd0, cause}, 32'd0);
        check("R12", "reset tval", tval, 32'd0);
        @(negedge clk);
        insn = W_NOP;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R12", "first cycle", {31'd0, illegal}, 32'd0);

        // R1
        drive("R1", 32'h0, 2'd3, 0, 0, 0, 1, 1);
        drive("R1", 32'h0, 2'd1, 0, 0, 0, 1, 1);
        drive("R1", 32'h0, 2'd0, 1, 1, 1, 0, 1);
        // R12 latency: trap word then benign word on consecutive cycles
        drive("R12", W_NOP, 2'd1, 1, 1, 1, 1, 0);
        // R2
        drive("R2", W_WFI, 2'd1, 0, 1, 1, 1, 0);
        drive("R2", W_WFI, 2'd1, 1, 0, 0, 1, 1);
        // R3
        drive("R3", W_SFENCE, 2'd1, 1, 0, 1, 1, 0);
        drive("R3", W_SFENCE, 2'd1, 0, 1, 0, 1, 1);
        // R4
        drive("R4", W_ATP_RD, 2'd1, 0, 0, 0, 1, 0);
        drive("R4", W_ATP_RD, 2'd1, 0, 1, 0, 1, 1);
        drive("R4", W_ATP_WR, 2'd1, 0, 1, 0, 1, 1);
        drive("R4", W_ATP_F4, 2'd1, 0, 1, 0, 1, 0);
        // R5
        drive("R5", W_SRET, 2'd1, 1, 1, 0, 1, 0);
        drive("R5", W_SRET, 2'd1, 0, 0, 1, 1, 1);
        // R6
        drive("R6", W_WFI, 2'd3, 1, 1, 1, 1, 0);
        drive("R6", W_SRET, 2'd3, 1, 1, 1, 1, 0);
        drive("R6", W_SFENCE, 2'd3, 1, 1, 1, 1, 0);
        drive("R6", W_ATP_RD, 2'd3, 1, 1, 1, 0, 0);
        // R7
        drive("R7", W_WFI, 2'd0, 0, 0, 0, 1, 1);
        drive("R7", W_SRET, 2'd0, 0, 0, 0, 1, 1);
        drive("R7", W_SFENCE, 2'd0, 0, 0, 0, 1, 1);
        drive("R7", W_ATP_RD, 2'd0, 0, 0, 0, 1, 1);
        drive("R7", W_WFI, 2'd2, 0, 0, 0, 1, 1);
        // R8
        drive("R8", W_SRET, 2'd1, 0, 0, 0, 0, 1);
        drive("R8", W_SFENCE, 2'd1, 0, 0, 0, 0, 1);
        drive("R8", W_ATP_RD, 2'd1, 0, 0, 0, 0, 1);
        drive("R8", W_WFI, 2'd1, 0, 0, 0, 0, 0);
        drive("R8", W_SRET, 2'd3, 0, 0, 0, 0, 0);
        // R11
        drive("R11", W_NOP, 2'd0, 1, 1, 1, 1, 0);
        drive("R11", W_MRET, 2'd1, 1, 1, 1, 1, 0);
        drive("R11", W_ECALL, 2'd0, 1, 1, 1, 0, 0);
        drive("R11", W_SST_RD, 2'd1, 1, 1, 1, 1, 0);

        @(negedge clk);
        insn = W_NOP;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule